// File: doc/BRIEF.md
# Tick Timer with Match Modes

This block is a processor's periodic tick timer. A 32-bit counter advances by one on every cycle in which the `tick_i` strobe is high, for example once per 50 ns from a 20 MHz tick. A control word sits beside it and holds a 28-bit period value, an interrupt enable, an interrupt pending flag and a two-bit mode. When the low 28 bits of the counter reach the period value, the block takes a match action. It sets the pending flag if interrupts are enabled. Then, depending on the mode, it clears the counter, freezes it, or lets it run on.

Software reaches both words through a small register port. One address bit selects the word. Writes take effect at the next clock edge. Reads are combinational views of the current contents. The interrupt line is the pending flag gated by the enable.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous active-low reset, the counter (address 0) and the control word (address 1) both read 0, and `irq_o` is low.
- R2: While the mode is not 00 and the timer is not halted, each clock edge with `tick_i` high adds exactly one to the full 32-bit counter. Edges with `tick_i` low leave it unchanged.
- R3: A match occurs on the counting edge whose incremented value has bits [27:0] equal to the period field. Counter bits [31:28] do not take part in the comparison.
- R4: On a match with the enable bit (bit 29) set, the pending bit (bit 28) becomes 1. On a match with enable clear, pending is left alone. `irq_o` is high exactly when both pending and enable are 1.
- R5: In mode 01 (restart), the counter is loaded with 0 on the matching edge instead of the incremented value.
- R6: In mode 10 (one-shot), the counter keeps the matched value and ignores further ticks. It counts again only after a control-word write with a nonzero mode.
- R7: In mode 11 (continuous), the counter keeps incrementing through a match, with carries into bits [31:28]. The next match comes when bits [27:0] wrap around to the period again.
- R8: In mode 00 (disabled), ticks do not change the counter, and no match, pending change or halt takes place.
- R9: A control-word write with bit 28 at 0 clears pending, and one with bit 28 at 1 leaves pending as it was. A match with enable set in the same cycle still sets pending.
- R10: A write to the counter (address 0) loads the written value even when `tick_i` is high in the same cycle, and no match action is taken in that cycle.
- R11: The control word has this layout: mode in bits [31:30], enable in bit 29, pending in bit 28 and period in bits [27:0]. A write replaces the mode, enable and period fields with the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Timer tick strobe, one count per high cycle |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 counter, 1 control word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Timer interrupt request |

## Verification
The bench targets the edge where a match coincides with other events:
- A control write that clears pending at the same time. A design that lets the clear win would lose the interrupt.
- A counter write on a tick edge. A design that increments anyway would be off by one.
- A one-shot halt. A design that keeps counting after the match would never freeze.

Continuous mode is started just below a 28-bit wrap. A design that compares all 32 bits, or that fails to carry into the upper nibble, would miss or misplace the second match. Restart with interrupts disabled checks that the counter still clears while pending stays low.

// File: rtl/tt_pkg.sv
// Package: shared types and constants of the tick timer.
// Assumes a single clock domain; the mode encoding is fixed by the register layout.
package tt_pkg;

    // Action taken when the counter reaches the period value
    typedef enum logic [1:0] {
        TT_MODE_OFF     = 2'b00,
        TT_MODE_RESTART = 2'b01,
        TT_MODE_ONESHOT = 2'b10,
        TT_MODE_FREE    = 2'b11
    } tt_mode_e;

    // Register port addresses
    localparam logic TT_ADDR_COUNT = 1'b0;
    localparam logic TT_ADDR_CTRL  = 1'b1;

endpackage

// File: rtl/tt_compare.sv
// Module: tt_compare
// Works out the incremented counter value and flags a match when the low
// period bits of that value equal the programmed period. A match is only
// reported on a counting edge (step high). Purely combinational.
module tt_compare #(
    parameter int CNT_W    = 32,
    parameter int PERIOD_W = 28
) (
    input  logic [CNT_W-1:0]    count_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic                step_i,
    output logic [CNT_W-1:0]    count_inc_o,
    output logic                hit_o
);

    // Next value of the counter and period-field compare
    always_comb begin
        count_inc_o = count_i + {{(CNT_W-1){1'b0}}, 1'b1};
        hit_o       = step_i && (count_inc_o[PERIOD_W-1:0] == period_i);
    end

endmodule

// File: rtl/tt_counter.sv
// Module: tt_counter
// The 32-bit tick counter. A register write wins over counting; a counting
// edge loads the incremented value, or zero on a restart-mode match.
// Assumes step_i is already qualified by mode, halt state and write.
module tt_counter
    import tt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             step_i,
    input  logic             hit_i,
    input  tt_mode_e         mode_i,
    input  logic [CNT_W-1:0] count_inc_i,
    output logic [CNT_W-1:0] count_o
);

    // Counter register: write, then restart-on-match, then increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (wr_en_i) begin
            count_o <= wdata_i;
        end else if (step_i) begin
            if (hit_i && (mode_i == TT_MODE_RESTART)) begin
                count_o <= '0;
            end else begin
                count_o <= count_inc_i;
            end
        end
    end

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (count_o == $past(wdata_i))); // R10

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && hit_i && (mode_i == TT_MODE_RESTART)) |=> (count_o == '0)); // R5

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && step_i && !(hit_i && (mode_i == TT_MODE_RESTART)))
        |=> (count_o == $past(count_o) + 1'b1)); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !step_i) |=> $stable(count_o)); // R8

endmodule

// File: rtl/tt_ctrl_reg.sv
// Module: tt_ctrl_reg
// Control word of the timer: period, interrupt enable, interrupt pending and
// mode, plus a hidden halt flag set by a one-shot match and cleared by any
// control write. Pending is set by an enabled match and cleared only by a
// write of 0 to its bit; a match in the same cycle wins over the clear.
module tt_ctrl_reg
    import tt_pkg::*;
#(
    parameter int PERIOD_W = 28,
    localparam int REG_W   = PERIOD_W + 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [REG_W-1:0]    wdata_i,
    input  logic                hit_i,
    output logic [PERIOD_W-1:0] period_o,
    output logic                ie_o,
    output logic                pend_o,
    output tt_mode_e            mode_o,
    output logic                running_o,
    output logic [REG_W-1:0]    word_o
);

    localparam int PEND_BIT = PERIOD_W;
    localparam int IE_BIT   = PERIOD_W + 1;
    localparam int MODE_HI  = PERIOD_W + 3;

    logic halted;

    // Software-owned fields: period, enable and mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_o <= '0;
            ie_o     <= 1'b0;
            mode_o   <= TT_MODE_OFF;
        end else if (wr_en_i) begin
            period_o <= wdata_i[PERIOD_W-1:0];
            ie_o     <= wdata_i[IE_BIT];
            mode_o   <= tt_mode_e'(wdata_i[MODE_HI -: 2]);
        end
    end

    // Pending flag: write-0-to-clear, set by an enabled match (set wins)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
        end else begin
            pend_o <= (wr_en_i ? (pend_o & wdata_i[PEND_BIT]) : pend_o) | (hit_i & ie_o);
        end
    end

    // Halt flag: set at a one-shot match, released by a control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted <= 1'b0;
        end else if (wr_en_i) begin
            halted <= 1'b0;
        end else if (hit_i && (mode_o == TT_MODE_ONESHOT)) begin
            halted <= 1'b1;
        end
    end

    // Counting permission and read-back view of the control word
    always_comb begin
        running_o = (mode_o != TT_MODE_OFF) && !halted;
        word_o    = {mode_o, ie_o, pend_o, period_o};
    end

    AST_PEND_SET_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && ie_o) |=> pend_o); // R4

    AST_PEND_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wdata_i[PEND_BIT] && pend_o) |=> pend_o); // R9

    AST_PEND_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wdata_i[PEND_BIT] && !(hit_i && ie_o)) |=> !pend_o); // R9

    AST_ONESHOT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && hit_i && (mode_o == TT_MODE_ONESHOT)) |=> !running_o); // R6

    AST_WRITE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wdata_i[MODE_HI -: 2] != 2'b00)) |=> running_o); // R6

endmodule

// File: rtl/tick_timer.sv
// Module: tick_timer
// Top of the tick timer: counter, period compare and control word behind a
// one-bit-address register port. Assumes tick_i is a single-cycle strobe in
// the clk domain; reads are combinational from the current registers.
module tick_timer
    import tt_pkg::*;
#(
    parameter int CNT_W = 32,
    localparam int PERIOD_W = CNT_W - 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             reg_wr_i,
    input  logic             reg_addr_i,
    input  logic [CNT_W-1:0] reg_wdata_i,
    output logic [CNT_W-1:0] reg_rdata_o,
    output logic             irq_o
);

    logic                cnt_wr;
    logic                ctrl_wr;
    logic                step;
    logic                hit;
    logic                running;
    logic                ie;
    logic                pend;
    tt_mode_e            mode;
    logic [PERIOD_W-1:0] period;
    logic [CNT_W-1:0]    count;
    logic [CNT_W-1:0]    count_inc;
    logic [CNT_W-1:0]    ctrl_word;

    // Write decode and counting qualification
    always_comb begin
        cnt_wr  = reg_wr_i && (reg_addr_i == TT_ADDR_COUNT);
        ctrl_wr = reg_wr_i && (reg_addr_i == TT_ADDR_CTRL);
        step    = tick_i && running && !cnt_wr;
    end

    tt_compare #(
        .CNT_W    (CNT_W),
        .PERIOD_W (PERIOD_W)
    ) cmp_i (
        .count_i     (count),
        .period_i    (period),
        .step_i      (step),
        .count_inc_o (count_inc),
        .hit_o       (hit)
    );

    tt_counter #(
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (cnt_wr),
        .wdata_i     (reg_wdata_i),
        .step_i      (step),
        .hit_i       (hit),
        .mode_i      (mode),
        .count_inc_i (count_inc),
        .count_o     (count)
    );

    tt_ctrl_reg #(
        .PERIOD_W (PERIOD_W)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (ctrl_wr),
        .wdata_i   (reg_wdata_i),
        .hit_i     (hit),
        .period_o  (period),
        .ie_o      (ie),
        .pend_o    (pend),
        .mode_o    (mode),
        .running_o (running),
        .word_o    (ctrl_word)
    );

    // Read mux and interrupt output
    always_comb begin
        reg_rdata_o = (reg_addr_i == TT_ADDR_CTRL) ? ctrl_word : count;
        irq_o       = pend && ie;
    end

    AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == TT_MODE_OFF) && !cnt_wr) |=> $stable(count)); // R8

    AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TT_MODE_OFF) |-> !hit); // R8

    AST_FREE_CARRIES: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (mode == TT_MODE_FREE) && !cnt_wr) |=> (count == $past(count) + 1'b1)); // R7

endmodule

// File: tb/tick_timer_tb_top.sv
`timescale 1ns/1ps
// Bench for tick_timer: a behavioural reference model stepped on every clock
// and compared against the read port and interrupt line each cycle.
module tick_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr = 1'b0;
    logic        addr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";

    // Reference state
    logic [31:0] m_cnt = '0;
    logic [27:0] m_per = '0;
    logic        m_ie = 1'b0;
    logic        m_pend = 1'b0;
    logic [1:0]  m_mode = 2'b00;
    logic        m_halt = 1'b0;

    always #2 clk = ~clk;

    tick_timer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    function automatic logic [31:0] mk(input logic [1:0] md, input logic ie,
                                       input logic pd, input logic [27:0] per);
        return {md, ie, pd, per};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One clock of the reference model, from the inputs seen at the edge
    task automatic model_step(input logic tk, input logic w, input logic a,
                              input logic [31:0] d);
        logic [31:0] inc;
        logic        stp, hit, wc, wk;
        wc  = w && !a;
        wk  = w && a;
        stp = tk && (m_mode != 2'b00) && !m_halt && !wc;
        inc = m_cnt + 1;
        hit = stp && (inc[27:0] == m_per);
        if (!rst_n) begin
            m_cnt = '0; m_per = '0; m_ie = 0; m_pend = 0; m_mode = 0; m_halt = 0;
            return;
        end
        m_pend = (wk ? (m_pend & d[28]) : m_pend) | (hit & m_ie);
        if (wk) m_halt = 1'b0;
        else if (hit && m_mode == 2'b10) m_halt = 1'b1;
        if (wc) m_cnt = d;
        else if (stp) m_cnt = (hit && m_mode == 2'b01) ? 32'h0 : inc;
        if (wk) begin
            m_per = d[27:0]; m_ie = d[29]; m_mode = d[31:30];
        end
    endtask

    // Drive one cycle, advance the model, compare at the falling edge
    task automatic cyc(input logic tk, input logic w, input logic a,
                       input logic [31:0] d);
        tick = tk; wr = w; addr = a; wdata = d;
        @(posedge clk);
        model_step(tk, w, a, d);
        @(negedge clk);
        check(cur_req, a ? "ctrl read" : "count read", rdata,
              a ? mk(m_mode, m_ie, m_pend, m_per) : m_cnt);
        check(cur_req, "irq", {31'h0, irq}, {31'h0, m_pend & m_ie});
    endtask

    task automatic idle(input int n, input logic tk);
        for (int i = 0; i < n; i++) cyc(tk, 1'b0, i[0], 32'h0);
    endtask

    task automatic peek(input logic a, output logic [31:0] v);
        cyc(1'b0, 1'b0, a, 32'h0);
        v = rdata;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        @(negedge clk);
        cur_req = "R1";
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, i[0], 32'h0);
        rst_n = 1'b1;
        peek(1'b0, v); check("R1", "count after reset", v, 32'h0);
        peek(1'b1, v); check("R1", "ctrl after reset", v, 32'h0);

        // Disabled mode: ticks are ignored
        cur_req = "R8";
        idle(10, 1'b1);
        peek(1'b0, v); check("R8", "count frozen in mode 00", v, 32'h0);

        // Continuous counting with an irregular tick pattern
        cur_req = "R2";
        cyc(1'b0, 1'b1, 1'b1, mk(2'b11, 1'b0, 1'b0, 28'h0FFFFFF));
        for (int i = 0; i < 24; i++) cyc((i % 3) != 1, 1'b0, i[0], 32'h0);
        peek(1'b0, v); check("R2", "count after 16 ticks", v, 32'd16);

        // Layout read-back
        cur_req = "R11";
        cyc(1'b0, 1'b1, 1'b1, mk(2'b00, 1'b1, 1'b1, 28'h0ABCDEF));
        peek(1'b1, v); check("R11", "ctrl fields", v, mk(2'b00, 1'b1, 1'b0, 28'h0ABCDEF));

        // Restart mode with interrupt enabled
        cur_req = "R5";
        cyc(1'b0, 1'b1, 1'b0, 32'h0);
        cyc(1'b0, 1'b1, 1'b1, mk(2'b01, 1'b1, 1'b0, 28'd4));
        idle(3, 1'b1);
        peek(1'b0, v); check("R5", "count before match", v, 32'd3);
        cyc(1'b1, 1'b0, 1'b0, 32'h0);
        check("R5", "count cleared at match", rdata, 32'h0);
        check("R4", "irq after enabled match", {31'h0, irq}, 32'h1);
        idle(12, 1'b1);

        // Pending clear rules
        cur_req = "R9";
        cyc(1'b0, 1'b1, 1'b1, mk(2'b01, 1'b1, 1'b1, 28'd4));
        peek(1'b1, v); check("R9", "write 1 keeps pending", {31'h0, v[28]}, 32'h1);
        cyc(1'b0, 1'b1, 1'b1, mk(2'b01, 1'b1, 1'b0, 28'd4));
        peek(1'b1, v); check("R9", "write 0 clears pending", {31'h0, v[28]}, 32'h0);
        cyc(1'b0, 1'b1, 1'b0, 32'd3);
        cyc(1'b1, 1'b1, 1'b1, mk(2'b01, 1'b1, 1'b0, 28'd4));
        check("R9", "match beats clear", {31'h0, rdata[28]}, 32'h1);

        // Counter write against a tick
        cur_req = "R10";
        cyc(1'b0, 1'b1, 1'b1, mk(2'b11, 1'b0, 1'b0, 28'd100));
        cyc(1'b1, 1'b1, 1'b0, 32'd99);
        check("R10", "write beats increment", rdata, 32'd99);
        cyc(1'b1, 1'b1, 1'b0, 32'd99);
        peek(1'b1, v); check("R10", "no match on write edge", {31'h0, v[28]}, 32'h0);

        // One-shot halt and resume
        cur_req = "R6";
        cyc(1'b0, 1'b1, 1'b0, 32'h0);
        cyc(1'b0, 1'b1, 1'b1, mk(2'b10, 1'b1, 1'b0, 28'd3));
        idle(12, 1'b1);
        peek(1'b0, v); check("R6", "halted at matched value", v, 32'd3);
        cyc(1'b0, 1'b1, 1'b1, mk(2'b10, 1'b1, 1'b0, 28'd9));
        idle(4, 1'b1);
        peek(1'b0, v); check("R6", "counting after rearm", v, 32'd7);

        // Continuous mode across a 28-bit wrap
        cur_req = "R7";
        cyc(1'b0, 1'b1, 1'b1, mk(2'b11, 1'b1, 1'b0, 28'd5));
        cyc(1'b0, 1'b1, 1'b0, 32'h0FFFFFF0);
        idle(21, 1'b1);
        peek(1'b0, v); check("R7", "count after wrap", v, 32'h10000005);
        cur_req = "R3";
        peek(1'b1, v); check("R3", "match on low bits only", {31'h0, v[28]}, 32'h1);
        cur_req = "R7";
        idle(6, 1'b1);

        // Match with enable clear: action without pending
        cur_req = "R4";
        cyc(1'b0, 1'b1, 1'b0, 32'h0);
        cyc(1'b0, 1'b1, 1'b1, mk(2'b01, 1'b0, 1'b0, 28'd2));
        idle(2, 1'b1);
        peek(1'b0, v); check("R4", "restart without enable", v, 32'h0);
        peek(1'b1, v); check("R4", "pending stays low", {31'h0, v[28]}, 32'h0);
        check("R4", "irq low", {31'h0, irq}, 32'h0);
        idle(10, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule